// File: doc/BRIEF.md
# E1/T1 All-Ones Alarm Detector

This block watches a recovered serial bitstream for an alarm indication signal: a line that carries almost nothing but ones. Each received bit arrives with a one-cycle strobe. The block cuts the stream into fixed, back-to-back windows and counts the zeros in each window. A window with too few zeros is called "sparse". Counting a small number of zeros, rather than demanding a perfect run of ones, lets detection survive a line bit error rate of about one in a thousand.

A mode input picks one of two rule sets:

- **E1 mode.** Windows are 512 bits long. The alarm is raised only when two sparse windows arrive back to back.
- **T1 mode.** Windows are 4632 bits long, which is 3 ms at 1.544 Mbit/s. A single sparse window raises the alarm.

The alarm is a level output. A separate one-cycle event output pulses when the alarm rises, and a mask input can suppress that pulse. Changing the mode starts detection over from scratch.

Top module: `ais_detector`

## Requirements
- R1: While reset is asserted and after it is released, `alarm` and `irq` are 0.
- R2: In E1 mode (`mode_t1`=0), `alarm` becomes 1 when two consecutive 512-bit windows are each sparse. It becomes visible two clock cycles after the strobe that ends the second window.
- R3: In E1 mode, a single sparse window does not raise `alarm` when the window before it or the window after it is not sparse.
- R4: In E1 mode, a window with exactly 2 zeros counts as sparse. A window with exactly 3 zeros does not.
- R5: In E1 mode, `alarm` returns to 0 at the end of a window that holds 3 or more zeros.
- R6: In T1 mode (`mode_t1`=1), a single 4632-bit window with fewer than 6 zeros sets `alarm`. It becomes visible two cycles after the window's last strobe.
- R7: In T1 mode, a window with 6 or more zeros leaves `alarm` at 0, or clears it.
- R8: `bit_in` is ignored on cycles where `bit_en` is 0. Such cycles neither count as bits nor add zeros.
- R9: `irq` is a one-cycle pulse in the same cycle that `alarm` rises, provided `irq_mask` is 0. When `irq_mask` is 1, no pulse is produced.
- R10: A change of `mode_t1` clears `alarm` one cycle later. It also restarts the window position, the zero count and the run of sparse windows.
- R11: Windows are non-overlapping and free-running from reset or from a mode change. The strobe count alone decides where a window ends, so no window ends before its full length of strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe: `bit_in` is valid this cycle |
| bit_in | input | 1 | Received data bit |
| mode_t1 | input | 1 | 0 selects E1 rules, 1 selects T1 rules |
| irq_mask | input | 1 | 1 suppresses the `irq` pulse |
| alarm | output | 1 | Alarm level |
| irq | output | 1 | One-cycle pulse when the alarm rises (if unmasked) |

## Verification
The hardest situation to reach is the E1 run rule at its boundary. One sparse window must be shown not to be enough, and the run must be broken and rebuilt across a non-sparse window. The table walks the line through exactly this sequence:

1. normal traffic;
2. one sparse window;
3. a second sparse window;
4. a window with exactly three zeros;
5. a lone sparse window that is then broken.

Each step checks both the level and the number of pulses. Directed tests then pin the exact strobe at which each window ends, using a run one strobe short followed by the final strobe. Further directed tests interleave idle zero bits between strobes, and switch mode while the alarm is high.

// File: rtl/ais_pkg.sv
package ais_pkg;

    typedef enum logic {
        MODE_E1 = 1'b0,
        MODE_T1 = 1'b1
    } ais_mode_e;

    // Result of one finished window, valid for one cycle
    typedef struct packed {
        logic done;
        logic sparse;
    } ais_verdict_t;

endpackage

// File: rtl/ais_window.sv
module ais_window
    import ais_pkg::*;
#(
    parameter int E1_LEN  = 512,
    parameter int T1_LEN  = 4632,
    parameter int E1_ZMIN = 3,
    parameter int T1_ZMIN = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  ais_mode_e    mode,
    input  logic         bit_en,
    input  logic         bit_in,
    output ais_verdict_t verdict
);
    localparam int LMAX = (T1_LEN > E1_LEN) ? T1_LEN : E1_LEN;
    localparam int ZMAX = (T1_ZMIN > E1_ZMIN) ? T1_ZMIN : E1_ZMIN;
    localparam int PW   = $clog2(LMAX);
    localparam int ZW   = $clog2(ZMAX + 1);

    typedef struct packed {
        logic [PW-1:0] pos;
        logic [ZW-1:0] zeros;
        ais_verdict_t  verdict;
    } win_t;

    win_t win_d, win_q;
    logic [PW-1:0] last_pos;
    logic [ZW-1:0] zmin;
    logic [ZW-1:0] zeros_inc;

    always_comb begin
        last_pos  = (mode == MODE_T1) ? PW'(T1_LEN - 1) : PW'(E1_LEN - 1);
        zmin      = (mode == MODE_T1) ? ZW'(T1_ZMIN) : ZW'(E1_ZMIN);
        zeros_inc = (!bit_in && win_q.zeros < zmin) ? win_q.zeros + 1'b1 : win_q.zeros;
        win_d         = win_q;
        win_d.verdict = '0;
        if (clear) begin
            win_d.pos   = '0;
            win_d.zeros = '0;
        end else if (bit_en) begin
            if (win_q.pos == last_pos) begin
                win_d.verdict.done   = 1'b1;
                win_d.verdict.sparse = (zeros_inc < zmin);
                win_d.pos            = '0;
                win_d.zeros          = '0;
            end else begin
                win_d.pos   = win_q.pos + 1'b1;
                win_d.zeros = zeros_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign verdict = win_q.verdict;

    p_pos_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.pos <= last_pos);
    p_zero_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.zeros <= zmin);
    p_done_at_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.done |-> ($past(bit_en) && win_q.pos == '0));

endmodule

// File: rtl/ais_alarm.sv
module ais_alarm
    import ais_pkg::*;
#(
    parameter int E1_RUN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  ais_mode_e    mode,
    input  ais_verdict_t verdict,
    input  logic         irq_mask,
    output logic         alarm,
    output logic         irq
);
    localparam int RW = $clog2(E1_RUN + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          alarm;
        logic          irq;
    } alm_t;

    alm_t alm_d, alm_q;
    logic [RW-1:0] run_next;

    always_comb begin
        run_next  = (alm_q.run < RW'(E1_RUN)) ? alm_q.run + 1'b1 : alm_q.run;
        alm_d     = alm_q;
        alm_d.irq = 1'b0;
        if (clear) begin
            alm_d.run   = '0;
            alm_d.alarm = 1'b0;
        end else if (verdict.done) begin
            if (!verdict.sparse) begin
                alm_d.run   = '0;
                alm_d.alarm = 1'b0;
            end else if (mode == MODE_T1) begin
                alm_d.alarm = 1'b1;
            end else begin
                alm_d.run   = run_next;
                alm_d.alarm = (run_next == RW'(E1_RUN));
            end
        end
        alm_d.irq = alm_d.alarm & ~alm_q.alarm & ~irq_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alm_q <= '0;
        else        alm_q <= alm_d;
    end

    assign alarm = alm_q.alarm;
    assign irq   = alm_q.irq;

    p_irq_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (alarm && !$past(alarm)));
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(irq_mask));
    p_alarm_moves_on_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm != $past(alarm)) |-> $past(verdict.done || clear));
    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !alarm);
    p_e1_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alarm) && $past(mode) == MODE_E1) |-> ($past(alm_q.run) == RW'(E1_RUN - 1)));

endmodule

// File: rtl/ais_detector.sv
module ais_detector
    import ais_pkg::*;
#(
    parameter int E1_LEN  = 512,
    parameter int T1_LEN  = 4632,
    parameter int E1_ZMIN = 3,
    parameter int T1_ZMIN = 6,
    parameter int E1_RUN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    input  logic mode_t1,
    input  logic irq_mask,
    output logic alarm,
    output logic irq
);
    ais_mode_e    mode_d, mode_q;
    logic         clear;
    ais_verdict_t verdict;

    always_comb begin
        mode_d = ais_mode_e'(mode_t1);
        clear  = (mode_d != mode_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_E1;
        else        mode_q <= mode_d;
    end

    ais_window #(
        .E1_LEN (E1_LEN),
        .T1_LEN (T1_LEN),
        .E1_ZMIN(E1_ZMIN),
        .T1_ZMIN(T1_ZMIN)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .mode   (mode_q),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .verdict(verdict)
    );

    ais_alarm #(
        .E1_RUN(E1_RUN)
    ) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .mode    (mode_q),
        .verdict (verdict),
        .irq_mask(irq_mask),
        .alarm   (alarm),
        .irq     (irq)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> (!alarm && !irq));

endmodule

// File: tb/ais_detector_tb.sv
`timescale 1ns/1ps
module ais_detector_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b1;
    logic mode_t1 = 1'b0;
    logic irq_mask = 1'b0;
    logic alarm, irq;

    int n_checks = 0;
    int n_fail = 0;
    int irq_cnt = 0;

    always #4 clk = ~clk;

    ais_detector u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .mode_t1(mode_t1), .irq_mask(irq_mask), .alarm(alarm), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    typedef struct packed {
        logic       mode;
        logic       mask;
        logic [3:0] nz;
        logic [1:0] nwin;
        logic       exp_alarm;
        logic [1:0] exp_irq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'd10, 2'd1, 1'b0, 2'd0},  // R3 normal traffic
        '{1'b0, 1'b0, 4'd2,  2'd1, 1'b0, 2'd0},  // R3 first sparse only
        '{1'b0, 1'b0, 4'd2,  2'd1, 1'b1, 2'd1},  // R2 R4 second sparse
        '{1'b0, 1'b0, 4'd0,  2'd2, 1'b1, 2'd0},  // R2 held
        '{1'b0, 1'b0, 4'd3,  2'd1, 1'b0, 2'd0},  // R5 R4 three zeros
        '{1'b0, 1'b0, 4'd1,  2'd1, 1'b0, 2'd0},  // R3 lone sparse
        '{1'b0, 1'b0, 4'd5,  2'd1, 1'b0, 2'd0},  // R3 run broken
        '{1'b0, 1'b1, 4'd0,  2'd2, 1'b1, 2'd0},  // R9 masked rise
        '{1'b1, 1'b0, 4'd5,  2'd1, 1'b1, 2'd1},  // R6 R10 T1 five zeros
        '{1'b1, 1'b0, 4'd6,  2'd1, 1'b0, 2'd0},  // R7 six zeros
        '{1'b1, 1'b0, 4'd7,  2'd1, 1'b0, 2'd0},  // R7 seven zeros
        '{1'b1, 1'b1, 4'd0,  2'd1, 1'b1, 2'd0},  // R9 masked T1
        '{1'b0, 1'b0, 4'd0,  2'd1, 1'b0, 2'd0},  // R10 back to E1
        '{1'b0, 1'b0, 4'd0,  2'd1, 1'b1, 2'd1}   // R2 run rebuilt
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // n strobes, zero at every 50th position for the first nz slots;
    // with gap set, an idle cycle carrying a zero follows each strobe
    task automatic send_bits(input int n, input int nz, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            bit_in = !((i % 50 == 0) && (i / 50 < nz));
            if (gap) begin
                @(negedge clk);
                bit_en = 1'b0;
                bit_in = 1'b0;
            end
        end
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = 1'b1;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        #1;
        check("R1 alarm in reset", int'(alarm), 0);
        check("R1 irq in reset", int'(irq), 0);
        do_reset();
        check("R1 alarm after reset", int'(alarm), 0);

        for (int v = 0; v < NV; v++) begin
            logic prev_alarm;
            prev_alarm = alarm;
            irq_mask = VECS[v].mask;
            if (mode_t1 != VECS[v].mode) begin
                @(negedge clk);
                mode_t1 = VECS[v].mode;
                repeat (2) @(negedge clk);
                if (prev_alarm) check("R10 alarm cleared by mode change", int'(alarm), 0);
            end
            irq_cnt = 0;
            for (int w = 0; w < int'(VECS[v].nwin); w++)
                send_bits(VECS[v].mode ? 4632 : 512, int'(VECS[v].nz), 1'b0);
            repeat (3) @(negedge clk);
            check($sformatf("R2-table v%0d alarm", v), int'(alarm), int'(VECS[v].exp_alarm));
            check($sformatf("R9 table v%0d irq count", v), irq_cnt, int'(VECS[v].exp_irq));
        end

        // R11 R2: exact E1 window boundary
        mode_t1 = 1'b0;
        irq_mask = 1'b0;
        do_reset();
        send_bits(1023, 0, 1'b0);
        repeat (3) @(negedge clk);
        check("R11 no alarm one strobe early", int'(alarm), 0);
        send_bits(1, 0, 1'b0);
        @(negedge clk);
        check("R2 alarm two cycles after last strobe", int'(alarm), 1);
        check("R9 irq with rise", int'(irq), 1);
        @(negedge clk);
        check("R9 irq lasts one cycle", int'(irq), 0);

        // R1: reset while alarm is high
        rst_n = 1'b0;
        #1;
        check("R1 reset clears alarm", int'(alarm), 0);
        check("R1 reset clears irq", int'(irq), 0);

        // R8: idle zero bits between strobes are ignored
        do_reset();
        send_bits(1024, 0, 1'b1);
        repeat (3) @(negedge clk);
        check("R8 idle zeros ignored", int'(alarm), 1);

        // R6 R11: exact T1 interval boundary
        mode_t1 = 1'b1;
        do_reset();
        send_bits(4631, 5, 1'b0);
        repeat (3) @(negedge clk);
        check("R11 T1 no alarm one strobe early", int'(alarm), 0);
        send_bits(1, 0, 1'b0);
        @(negedge clk);
        check("R6 T1 alarm at interval end", int'(alarm), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule